// File: doc/BRIEF.md
# Crosspoint Matrix Configuration Register

This block holds the routing program of an eight-output, eight-input crosspoint switch. A host loads a new program in one of two ways. In serial mode it sends a whole 32-bit word, one bit per falling edge of a programming clock. In parallel mode it writes one output's 4-bit setting, addressed by output number, on a single falling edge. Either way the bits land in a staging register. A level-sensitive update stage then passes the staging contents to the per-output source selects and enables while the update strobe is low, and holds them while it is high.

The last bit of the serial chain is brought out, so several blocks can be chained and loaded from one serial stream. Reset only disables the outputs. The source selects and the staging contents stay as they were, so after power-up a host must program every output before it relies on the selects. For checking, eight digital lanes are routed through the programmed matrix. The whole block runs on one fast system clock. The programming clock and the update strobe are sampled as levels on that clock.

Top module: `xbar_cfg_top`

## Requirements
- R1: A synchronous high `rst` drives every bit of `out_en` to 0 one clock later and leaves `src_sel` and the staging register unchanged; a later update restores the staged program.
- R2: In serial mode (`par_mode`=0) with `chip_en_n` low, each falling edge of `prog_clk` shifts `ser_din` into the 32-bit staging chain. After 32 shifts, output k's enable is the bit sent as number 31-(4k+3), counted from 0 in sending order, and its select follows as three bits, most significant first. Output 7's enable is sent first, and output 0's select bit 0 is sent last.
- R3: While `chip_en_n` is high, falling edges of `prog_clk` change neither the staging register nor, after a later update, any output.
- R4: While `upd_n` is high, `src_sel` and `out_en` hold their values through any shifting or writing. While `upd_n` is low, they follow the staging register one system clock behind, including its intermediate shift states.
- R5: `ser_dout` equals the last chain stage, so a bit shifted in on falling edge n appears on `ser_dout` after falling edge n+31 and leaves it on edge n+32.
- R6: In parallel mode (`par_mode`=1) with `chip_en_n` low, one falling edge of `prog_clk` writes `par_nib` into the slot of output `par_addr`. Bit 3 of the nibble is the enable and bits 2:0 are the select. All other slots are unchanged.
- R7: `lane_out[k]` equals `lane_in[src_sel[3k+2:3k]]` when `out_en[k]` is 1, and is registered one clock behind the select and enable.
- R8: When `out_en[k]` is 0, `lane_out[k]` is 0 whatever output k's select bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; clears the output enables only |
| chip_en_n | input | 1 | Active-low chip enable for shifting and parallel writes |
| prog_clk | input | 1 | Programming clock; acts on its falling edge |
| ser_din | input | 1 | Serial configuration data in |
| ser_dout | output | 1 | Last stage of the serial chain, for chaining |
| upd_n | input | 1 | Update strobe; low makes the update stage transparent |
| par_mode | input | 1 | 0 = serial mode, 1 = parallel mode |
| par_addr | input | 3 | Output number for a parallel write |
| par_nib | input | 4 | Parallel setting: bit 3 enable, bits 2:0 source select |
| lane_in | input | 8 | Digital input lanes for the matrix model |
| src_sel | output | 24 | Source select of output k in bits 3k+2:3k |
| out_en | output | 8 | Enable of output k in bit k |
| lane_out | output | 8 | Routed lanes; 0 on a disabled output |

## Verification
A corrupted staging slot stays invisible until the next update. It then shows on `src_sel` and `out_en` one clock after `upd_n` goes low, and on `lane_out` one clock after that. A wrong chain stage shows on `ser_dout` only when that bit reaches the end of the chain, up to 31 falling edges later. For this reason the serial output is compared with the expected chain after every shift once the chain is fully known. A reset that clears too much is caught at once on `src_sel`, and one that clears the staging register is caught on the first update after it.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;
  typedef enum logic {
    XB_SERIAL   = 1'b0,
    XB_PARALLEL = 1'b1
  } xb_mode_e;
endpackage

// File: rtl/xbar_edge_det.sv
module xbar_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic fall
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b0;
    else     sig_q <= sig;
  end

  // high during the system clock in which sig was seen going from 1 to 0
  assign fall = sig_q & ~sig;
endmodule

// File: rtl/xbar_stage_reg.sv
module xbar_stage_reg #(
  parameter int N_OUT = 8,
  parameter int SEL_W = 3
) (
  input  logic                       clk,
  input  logic                       shift_en,
  input  logic                       load_en,
  input  logic                       din,
  input  logic [$clog2(N_OUT)-1:0]   addr,
  input  logic [SEL_W:0]             nib,
  output logic [N_OUT*(SEL_W+1)-1:0] stage_q,
  output logic                       dout
);
  localparam int NIB_W   = SEL_W + 1;
  localparam int CHAIN_W = N_OUT * NIB_W;
  localparam int ADDR_W  = $clog2(N_OUT);

  logic [NIB_W-1:0]   slot_q [N_OUT];
  logic [CHAIN_W-1:0] shifted;

  assign shifted = {stage_q[CHAIN_W-2:0], din};

  // no reset: the staging contents survive a reset
  always_ff @(posedge clk) begin
    for (int k = 0; k < N_OUT; k++) begin
      if (shift_en)
        slot_q[k] <= shifted[k*NIB_W +: NIB_W];
      else if (load_en && addr == ADDR_W'(k))
        slot_q[k] <= nib;
    end
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_pack
    assign stage_q[g*NIB_W +: NIB_W] = slot_q[g];
  end

  assign dout = stage_q[CHAIN_W-1];
endmodule

// File: rtl/xbar_update_latch.sv
module xbar_update_latch #(
  parameter int N_OUT = 8,
  parameter int SEL_W = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       open,
  input  logic [N_OUT*(SEL_W+1)-1:0] stage_in,
  output logic [N_OUT*SEL_W-1:0]     sel_q,
  output logic [N_OUT-1:0]           en_q
);
  localparam int NIB_W = SEL_W + 1;

  logic [N_OUT*SEL_W-1:0] stage_sel;
  logic [N_OUT-1:0]       stage_en;

  for (genvar g = 0; g < N_OUT; g++) begin : g_split
    assign stage_sel[g*SEL_W +: SEL_W] = stage_in[g*NIB_W +: SEL_W];
    assign stage_en[g]                 = stage_in[g*NIB_W + SEL_W];
  end

  // enables: cleared by reset, otherwise follow staging while open
  always_ff @(posedge clk) begin
    if (rst)       en_q <= '0;
    else if (open) en_q <= stage_en;
  end

  // selects: never reset, frozen during reset
  always_ff @(posedge clk) begin
    if (!rst && open) sel_q <= stage_sel;
  end
endmodule

// File: rtl/xbar_lane_mux.sv
module xbar_lane_mux #(
  parameter int N_OUT = 8,
  parameter int SEL_W = 3
) (
  input  logic                   clk,
  input  logic [(1<<SEL_W)-1:0]  lane_in,
  input  logic [N_OUT*SEL_W-1:0] sel,
  input  logic [N_OUT-1:0]       en,
  output logic [N_OUT-1:0]       lane_out
);
  logic [N_OUT-1:0] routed;

  for (genvar g = 0; g < N_OUT; g++) begin : g_route
    assign routed[g] = en[g] & lane_in[sel[g*SEL_W +: SEL_W]];
  end

  always_ff @(posedge clk) lane_out <= routed;
endmodule

// File: rtl/xbar_cfg_top.sv
module xbar_cfg_top
  import xbar_cfg_pkg::*;
#(
  parameter int N_OUT = 8,
  parameter int SEL_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     chip_en_n,
  input  logic                     prog_clk,
  input  logic                     ser_din,
  output logic                     ser_dout,
  input  logic                     upd_n,
  input  logic                     par_mode,
  input  logic [$clog2(N_OUT)-1:0] par_addr,
  input  logic [SEL_W:0]           par_nib,
  input  logic [(1<<SEL_W)-1:0]    lane_in,
  output logic [N_OUT*SEL_W-1:0]   src_sel,
  output logic [N_OUT-1:0]         out_en,
  output logic [N_OUT-1:0]         lane_out
);
  localparam int NIB_W   = SEL_W + 1;
  localparam int CHAIN_W = N_OUT * NIB_W;

  xb_mode_e           mode;
  logic               pclk_fall;
  logic               shift_fire;
  logic               load_fire;
  logic [CHAIN_W-1:0] stage_q;

  assign mode       = xb_mode_e'(par_mode);
  assign shift_fire = pclk_fall & ~chip_en_n & (mode == XB_SERIAL);
  assign load_fire  = pclk_fall & ~chip_en_n & (mode == XB_PARALLEL);

  xbar_edge_det u_edge (
    .clk  (clk),
    .rst  (rst),
    .sig  (prog_clk),
    .fall (pclk_fall)
  );

  xbar_stage_reg #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_stage (
    .clk      (clk),
    .shift_en (shift_fire),
    .load_en  (load_fire),
    .din      (ser_din),
    .addr     (par_addr),
    .nib      (par_nib),
    .stage_q  (stage_q),
    .dout     (ser_dout)
  );

  xbar_update_latch #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_upd (
    .clk      (clk),
    .rst      (rst),
    .open     (~upd_n),
    .stage_in (stage_q),
    .sel_q    (src_sel),
    .en_q     (out_en)
  );

  xbar_lane_mux #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_mux (
    .clk      (clk),
    .lane_in  (lane_in),
    .sel      (src_sel),
    .en       (out_en),
    .lane_out (lane_out)
  );
endmodule

// File: rtl/xbar_cfg_chk.sv
module xbar_cfg_chk #(
  parameter int N_OUT = 8,
  parameter int SEL_W = 3
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       chip_en_n,
  input logic                       upd_n,
  input logic                       shift_fire,
  input logic [N_OUT*(SEL_W+1)-1:0] stage_q,
  input logic                       ser_dout,
  input logic [N_OUT*SEL_W-1:0]     src_sel,
  input logic [N_OUT-1:0]           out_en,
  input logic [N_OUT-1:0]           lane_out
);
  localparam int NIB_W   = SEL_W + 1;
  localparam int CHAIN_W = N_OUT * NIB_W;

  logic                   started;
  logic [N_OUT*SEL_W-1:0] st_sel;
  logic [N_OUT-1:0]       st_en;

  always_ff @(posedge clk) started <= 1'b1;

  for (genvar g = 0; g < N_OUT; g++) begin : g_ex
    assign st_sel[g*SEL_W +: SEL_W] = stage_q[g*NIB_W +: SEL_W];
    assign st_en[g]                 = stage_q[g*NIB_W + SEL_W];
  end

  // R1
  reset_clears_en_chk: assert property (@(posedge clk) disable iff (!started)
    rst |=> (out_en == '0));

  // R1
  reset_keeps_sel_chk: assert property (@(posedge clk) disable iff (!started)
    rst |=> (src_sel == $past(src_sel)));

  // R3
  ce_high_no_shift_chk: assert property (@(posedge clk) disable iff (rst)
    chip_en_n |=> $stable(stage_q));

  // R4
  upd_high_hold_chk: assert property (@(posedge clk) disable iff (rst)
    upd_n |=> ($stable(src_sel) && $stable(out_en)));

  // R4
  upd_low_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_n |=> ((src_sel == $past(st_sel)) && (out_en == $past(st_en))));

  // R5
  dout_chain_chk: assert property (@(posedge clk) disable iff (rst)
    shift_fire |=> (ser_dout == $past(stage_q[CHAIN_W-2])));

  // R8
  disabled_lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_en == '0) |=> (lane_out == '0));
endmodule

bind xbar_cfg_top xbar_cfg_chk #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .chip_en_n  (chip_en_n),
  .upd_n      (upd_n),
  .shift_fire (shift_fire),
  .stage_q    (stage_q),
  .ser_dout   (ser_dout),
  .src_sel    (src_sel),
  .out_en     (out_en),
  .lane_out   (lane_out)
);

// File: tb/tb_xbar_cfg_top.sv
module tb_xbar_cfg_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        chip_en_n = 1'b1;
  logic        prog_clk = 1'b0;
  logic        ser_din = 1'b0;
  logic        ser_dout;
  logic        upd_n = 1'b1;
  logic        par_mode = 1'b0;
  logic [2:0]  par_addr = '0;
  logic [3:0]  par_nib = '0;
  logic [7:0]  lane_in = '0;
  logic [23:0] src_sel;
  logic [7:0]  out_en;
  logic [7:0]  lane_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model of staging and outputs
  logic [31:0] m_stage = '0;
  logic [31:0] m_known = '0;
  logic [23:0] m_sel   = '0;
  logic [7:0]  m_en    = '0;

  always #2.5 clk = ~clk;

  xbar_cfg_top dut (
    .clk(clk), .rst(rst), .chip_en_n(chip_en_n), .prog_clk(prog_clk),
    .ser_din(ser_din), .ser_dout(ser_dout), .upd_n(upd_n), .par_mode(par_mode),
    .par_addr(par_addr), .par_nib(par_nib), .lane_in(lane_in),
    .src_sel(src_sel), .out_en(out_en), .lane_out(lane_out)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_lanes(input logic [7:0] lin,
                                           input logic [23:0] sel,
                                           input logic [7:0] en);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = en[k] & lin[sel[3*k +: 3]];
    return r;
  endfunction

  task automatic latch_model();
    for (int k = 0; k < 8; k++) begin
      m_sel[3*k +: 3] = m_stage[4*k +: 3];
      m_en[k]         = m_stage[4*k + 3];
    end
  endtask

  // one falling edge on the programming clock, with model update
  task automatic pfall();
    prog_clk = 1'b1;
    tick(2);
    prog_clk = 1'b0;
    tick(2);
    if (!chip_en_n) begin
      if (!par_mode) begin
        m_stage = {m_stage[30:0], ser_din};
        m_known = {m_known[30:0], 1'b1};
      end else begin
        m_stage[4*par_addr +: 4] = par_nib;
        m_known[4*par_addr +: 4] = 4'hF;
      end
    end
    if (!upd_n) latch_model();
  endtask

  task automatic shift_bit(input logic b);
    ser_din = b;
    pfall();
    // R5: last chain stage on ser_dout
    if (m_known[31]) check("R5 ser_dout", {31'd0, ser_dout}, {31'd0, m_stage[31]});
  endtask

  task automatic ser_word(input logic [31:0] w);
    par_mode = 1'b0;
    for (int i = 31; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic par_write(input logic [2:0] a, input logic [3:0] n);
    par_mode = 1'b1;
    par_addr = a;
    par_nib  = n;
    pfall();
    par_mode = 1'b0;
  endtask

  task automatic do_update();
    upd_n = 1'b0;
    tick(2);
    upd_n = 1'b1;
    tick(1);
    latch_model();
  endtask

  task automatic check_outs(input string req);
    check({req, " out_en"}, {24'd0, out_en}, {24'd0, m_en});
    check({req, " src_sel"}, {8'd0, src_sel}, {8'd0, m_sel});
  endtask

  task automatic check_lanes(input string req, input logic [7:0] lin);
    lane_in = lin;
    tick(2);
    check(req, {24'd0, lane_out}, {24'd0, exp_lanes(lin, m_sel, m_en)});
  endtask

  initial begin
    void'($urandom(32'h1A2B3C4D));
    tick(4);
    // R1: reset state, enables cleared
    check("R1 reset out_en", {24'd0, out_en}, 32'd0);
    check_lanes("R8 lanes zero after reset", 8'hFF);
    rst = 1'b0;
    chip_en_n = 1'b0;
    tick(2);

    // R2 + R4: shift a full word with update high, outputs must hold
    ser_word(32'hC5A3_91F7);
    check("R4 hold out_en", {24'd0, out_en}, 32'd0);
    do_update();
    // R2: out7 nibble = 4'hC -> enable 1, select 4; out0 nibble = 4'h7 -> disabled
    check("R2 out7 enable", {31'd0, out_en[7]}, 32'd1);
    check("R2 out7 select", {29'd0, src_sel[23:21]}, 32'd4);
    check("R2 out0 enable", {31'd0, out_en[0]}, 32'd0);
    check_outs("R2");
    check_lanes("R7 lanes", 8'b1011_0110);

    // R5: a second word pushes the first one out through ser_dout
    ser_word(32'h3E7B_0D42);
    do_update();
    check_outs("R2 second word");

    // R1: reset while programmed keeps selects and staging
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    m_en = '0;
    tick(1);
    check_outs("R1 after reset");
    check_lanes("R8 lanes after reset", 8'hFF);
    do_update();
    check_outs("R1 staging kept");

    // R3: chip enable high blocks shifting and writing
    chip_en_n = 1'b1;
    ser_word(32'hFFFF_FFFF);
    par_write(3'd2, 4'h0);
    do_update();
    check_outs("R3 ce high");
    chip_en_n = 1'b0;

    // R6: single parallel write changes one output only
    par_write(3'd3, 4'b1101);
    do_update();
    check("R6 out3 enable", {31'd0, out_en[3]}, 32'd1);
    check("R6 out3 select", {29'd0, src_sel[11:9]}, 32'd5);
    check_outs("R6");
    check_lanes("R7 lanes par", 8'b0010_0000);

    // R4: update low follows every intermediate shift state
    upd_n = 1'b0;
    tick(2);
    for (int i = 0; i < 4; i++) begin
      shift_bit(i[0]);
      check_outs("R4 transparent");
    end
    upd_n = 1'b1;
    tick(1);

    // R8: disabled output with arbitrary select routes nothing
    par_write(3'd5, 4'b0111);
    do_update();
    check_lanes("R8 disabled out5", 8'hFF);
    check("R8 lane5", {31'd0, lane_out[5]}, 32'd0);

    // random mix
    for (int it = 0; it < 40; it++) begin
      if ($urandom_range(0, 2) == 0) ser_word($urandom);
      else par_write(3'($urandom_range(0, 7)), 4'($urandom_range(0, 15)));
      if ($urandom_range(0, 3) != 0) begin
        do_update();
        check_outs("R2/R6 random");
      end else begin
        check_outs("R4 random hold");
      end
      check_lanes("R7 random lanes", 8'($urandom));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule